// File: doc/BRIEF.md
# Push-button Volume Step Controller

This block turns three active-low push buttons (volume up, volume down, mute) and an active-low standby input into one tap position shared by both stereo channels. Position 0 is no attenuation, 31 is the largest attenuation on the array, and code 32 is a separate mute code. Each button is synchronized, debounced and decoded into single commands. A sequencer adds a post-command lockout, two-rate auto-repeat while a direction button stays down, and rejection of chords (several buttons down together).

The result goes to a downstream wiper-update scheduler as a registered requested position and a one-cycle strobe that fires whenever that position changes. All timing is counted on a 1 kHz tick-enable input, so every millisecond figure below is a count of ticks.

Top module: `vol_step_ctrl`

## Requirements
- R1: A button counts as pressed only after its synchronized input has stayed low for DEB_MS (15) ticks. A release is filtered the same way. A shorter low pulse causes no step and no strobe.
- R2: After an accepted command, a new press that becomes valid within LOCK_MS (40) ticks is ignored for its whole duration, and no command is issued for it.
- R3: While a single up or down button stays held, the first automatic step comes HOLD_MS (1000) ticks after the press was accepted. The next 16 steps follow every SLOW_MS (250) ticks. After that, steps come every FAST_MS (125) ticks until release.
- R4: The position saturates and never wraps. Up at position 0 and down at position 31 leave the position unchanged and give no strobe.
- R5: An accepted mute press at a non-mute position stores that position and moves to code 32 in one step. The next accepted mute press restores the stored position. Holding mute never auto-repeats.
- R6: When two or more debounced buttons are down at the same time, no command is issued. Nothing is acted on until all buttons are released, and an auto-repeat in progress stops.
- R7: After a synchronous reset the requested position is 10 and the strobe is low.
- R8: While the standby input is low, the requested position is code 32 and button commands are ignored. When standby is released, the position held before standby returns.
- R9: The strobe is high for exactly one cycle each time the requested position changes, and at no other time.
- R10: While at the mute code, up and down presses change nothing and give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-cycle enable every millisecond |
| up_n | input | 1 | Volume-up button, active low, asynchronous |
| dn_n | input | 1 | Volume-down button, active low, asynchronous |
| mute_n | input | 1 | Mute toggle button, active low, asynchronous |
| stby_n | input | 1 | Standby, active low, asynchronous |
| req_pos_o | output | 6 | Requested tap position, 0..31, or 32 for mute/standby |
| req_vld_o | output | 1 | One-cycle strobe when req_pos_o changes |

## Verification
The bench drives low pulses just below and above the debounce length, to tell filtered glitches from real presses. It uses a second press placed inside the lockout window, to tell lockout from ordinary acceptance. Holds of several lengths go into both ends of the range: each length is chosen so the expected step count separates the initial delay, the slow rate and the fast rate, and the runs into the ends show saturation. Chords and mute/standby sequences check that nothing moves and that the strobe count equals the number of position changes.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int BTN_N    = 3;
  localparam int BTN_UP   = 0;
  localparam int BTN_DN   = 1;
  localparam int BTN_MUTE = 2;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DN   = 2'd2,
    CMD_MUTE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HELD = 2'd1,
    SEQ_DEAD = 2'd2
  } seq_e;
endpackage

// File: rtl/vsc_sync.sv
module vsc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/vsc_debounce.sv
module vsc_debounce #(
  parameter int DEB_MS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic raw_i,
  output logic stable_o
);
  localparam int CNT_W = $clog2(DEB_MS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (raw_i == stable_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == CNT_W'(DEB_MS - 1)) begin
        stable_q <= raw_i;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign stable_o = stable_q;

  // R1: the filtered level only moves toward a level the raw input already had
  a_r1_follows_raw: assert property (@(posedge clk) disable iff (rst)
    !$stable(stable_q) |-> ($past(raw_i) == stable_q));
endmodule

// File: rtl/vsc_press_seq.sv
module vsc_press_seq
  import vsc_pkg::*;
#(
  parameter int LOCK_MS   = 40,
  parameter int HOLD_MS   = 1000,
  parameter int SLOW_MS   = 250,
  parameter int FAST_MS   = 125,
  parameter int SLOW_REPS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [BTN_N-1:0] btn_i,
  output cmd_e             cmd_o
);
  localparam int LOCK_W = $clog2(LOCK_MS + 1);
  localparam int TMR_W  = $clog2(HOLD_MS + 1);
  localparam int REP_W  = $clog2(SLOW_REPS + 2);

  seq_e             state_q;
  logic [BTN_N-1:0] held_q;
  logic [LOCK_W-1:0] lock_q;
  logic [TMR_W-1:0] tmr_q;
  logic [REP_W-1:0] rep_q;
  logic [TMR_W-1:0] period;
  cmd_e             cmd_q;
  int               n_down;

  function automatic cmd_e btn2cmd(input logic [BTN_N-1:0] b);
    if (b[BTN_UP])      return CMD_UP;
    else if (b[BTN_DN]) return CMD_DN;
    else                return CMD_MUTE;
  endfunction

  always_comb begin
    n_down = $countones(btn_i);
    if (rep_q == '0)                          period = TMR_W'(HOLD_MS);
    else if (rep_q <= REP_W'(SLOW_REPS))      period = TMR_W'(SLOW_MS);
    else                                      period = TMR_W'(FAST_MS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      held_q  <= '0;
      lock_q  <= '0;
      tmr_q   <= '0;
      rep_q   <= '0;
      cmd_q   <= CMD_NONE;
    end else begin
      cmd_q <= CMD_NONE;
      if (tick_i && lock_q != '0) lock_q <= lock_q - 1'b1;
      unique case (state_q)
        SEQ_IDLE: begin
          if (n_down > 1) begin
            state_q <= SEQ_DEAD;
          end else if (n_down == 1) begin
            if (lock_q != '0) begin
              state_q <= SEQ_DEAD;
            end else begin
              cmd_q   <= btn2cmd(btn_i);
              held_q  <= btn_i;
              lock_q  <= LOCK_W'(LOCK_MS);
              tmr_q   <= '0;
              rep_q   <= '0;
              state_q <= SEQ_HELD;
            end
          end
        end
        SEQ_HELD: begin
          if (n_down == 0) begin
            state_q <= SEQ_IDLE;
          end else if (btn_i != held_q) begin
            state_q <= SEQ_DEAD;
          end else if (!held_q[BTN_MUTE] && tick_i) begin
            if (tmr_q == period - 1'b1) begin
              cmd_q  <= btn2cmd(held_q);
              lock_q <= LOCK_W'(LOCK_MS);
              tmr_q  <= '0;
              if (rep_q != REP_W'(SLOW_REPS + 1)) rep_q <= rep_q + 1'b1;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
        end
        default: begin
          if (n_down == 0) state_q <= SEQ_IDLE;
        end
      endcase
    end
  end

  assign cmd_o = cmd_q;

  // Checker state: ticks since the last issued command, saturating
  logic [LOCK_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)                                  gap_q <= LOCK_W'(LOCK_MS);
    else if (cmd_q != CMD_NONE)               gap_q <= '0;
    else if (tick_i && gap_q != LOCK_W'(LOCK_MS)) gap_q <= gap_q + 1'b1;
  end

  // R2: two commands are never closer than the lockout window
  a_r2_lockout_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NONE) |-> (gap_q == LOCK_W'(LOCK_MS)));
  // R6: a chord never yields a command
  a_r6_chord_silent: assert property (@(posedge clk) disable iff (rst)
    ($countones(btn_i) > 1) |=> (cmd_q == CMD_NONE));
  // R9: a command is a single-cycle pulse
  a_r9_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NONE) |=> (cmd_q == CMD_NONE));
endmodule

// File: rtl/vsc_pos_unit.sv
module vsc_pos_unit
  import vsc_pkg::*;
#(
  parameter int TAPS      = 32,
  parameter int RESET_TAP = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  cmd_e                        cmd_i,
  input  logic                        stby_i,
  output logic [$clog2(TAPS+1)-1:0]   req_pos_o,
  output logic                        req_vld_o
);
  localparam int TAP_W = $clog2(TAPS + 1);
  localparam logic [TAP_W-1:0] MUTE_CODE = TAP_W'(TAPS);
  localparam logic [TAP_W-1:0] LAST_TAP  = TAP_W'(TAPS - 1);

  logic [TAP_W-1:0] pos_q, save_q, out_q, out_d;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= TAP_W'(RESET_TAP);
      save_q <= TAP_W'(RESET_TAP);
    end else if (!stby_i) begin
      unique case (cmd_i)
        CMD_UP:   if (pos_q != '0 && pos_q != MUTE_CODE) pos_q <= pos_q - 1'b1;
        CMD_DN:   if (pos_q < LAST_TAP) pos_q <= pos_q + 1'b1;
        CMD_MUTE: begin
          if (pos_q == MUTE_CODE) begin
            pos_q <= save_q;
          end else begin
            save_q <= pos_q;
            pos_q  <= MUTE_CODE;
          end
        end
        default: ;
      endcase
    end
  end

  assign out_d = stby_i ? MUTE_CODE : pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= TAP_W'(RESET_TAP);
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= (out_d != out_q);
    end
  end

  assign req_pos_o = out_q;
  assign req_vld_o = vld_q;

  // R4: the requested position stays inside the legal codes
  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    req_pos_o <= MUTE_CODE);
  // R8: standby forces the mute code at the output
  a_r8_stby_forced: assert property (@(posedge clk) disable iff (rst)
    stby_i |=> (req_pos_o == MUTE_CODE));
  // R9: strobe marks a change, silence marks no change
  a_r9_strobe_change: assert property (@(posedge clk) disable iff (rst)
    req_vld_o |-> (req_pos_o != $past(req_pos_o)));
  a_r9_quiet_stable: assert property (@(posedge clk) disable iff (rst)
    !req_vld_o |-> $stable(req_pos_o));
  // R10: down at the mute code leaves the position alone
  a_r10_muted_dn: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_DN && pos_q == MUTE_CODE) |=> (pos_q == MUTE_CODE));
  // R5: a mute press at the mute code restores the stored position
  a_r5_restore: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_MUTE && !stby_i && pos_q == MUTE_CODE) |=> (pos_q == $past(save_q)));
endmodule

// File: rtl/vol_step_ctrl.sv
module vol_step_ctrl
  import vsc_pkg::*;
#(
  parameter int TAPS      = 32,
  parameter int RESET_TAP = 10,
  parameter int DEB_MS    = 15,
  parameter int LOCK_MS   = 40,
  parameter int HOLD_MS   = 1000,
  parameter int SLOW_MS   = 250,
  parameter int FAST_MS   = 125,
  parameter int SLOW_REPS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_ms,
  input  logic                      up_n,
  input  logic                      dn_n,
  input  logic                      mute_n,
  input  logic                      stby_n,
  output logic [$clog2(TAPS+1)-1:0] req_pos_o,
  output logic                      req_vld_o
);
  logic [BTN_N:0]   sync_n;
  logic [BTN_N-1:0] btn_raw, btn_deb;
  cmd_e             cmd;

  vsc_sync #(.W(BTN_N + 1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({stby_n, mute_n, dn_n, up_n}),
    .sync_o  (sync_n)
  );

  assign btn_raw = ~sync_n[BTN_N-1:0];

  for (genvar g = 0; g < BTN_N; g++) begin : g_deb
    vsc_debounce #(.DEB_MS(DEB_MS)) u_deb (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick_ms),
      .raw_i    (btn_raw[g]),
      .stable_o (btn_deb[g])
    );
  end

  vsc_press_seq #(
    .LOCK_MS(LOCK_MS), .HOLD_MS(HOLD_MS), .SLOW_MS(SLOW_MS),
    .FAST_MS(FAST_MS), .SLOW_REPS(SLOW_REPS)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_ms),
    .btn_i  (btn_deb),
    .cmd_o  (cmd)
  );

  vsc_pos_unit #(.TAPS(TAPS), .RESET_TAP(RESET_TAP)) u_pos (
    .clk       (clk),
    .rst       (rst),
    .cmd_i     (cmd),
    .stby_i    (~sync_n[BTN_N]),
    .req_pos_o (req_pos_o),
    .req_vld_o (req_vld_o)
  );
endmodule

// File: tb/test_vol_step_ctrl.sv
module test_vol_step_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MUTE_CODE  = 32;
  localparam int SETTLE     = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b1;
  logic up_n = 1'b1, dn_n = 1'b1, mute_n = 1'b1, stby_n = 1'b1;
  logic [5:0] req_pos_o;
  logic       req_vld_o;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int model_pos = 10;

  always #(CLK_PERIOD/2) clk = ~clk;

  vol_step_ctrl i_vol_step_ctrl (
    .clk(clk), .rst(rst), .tick_ms(tick_ms),
    .up_n(up_n), .dn_n(dn_n), .mute_n(mute_n), .stby_n(stby_n),
    .req_pos_o(req_pos_o), .req_vld_o(req_vld_o)
  );

  always @(negedge clk) if (!rst && req_vld_o) strobes++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Steps produced by a hold lasting len ticks (initial step plus auto-repeat)
  function automatic int steps_for(input int len);
    int n = 1;
    int t = 1000;
    int k = 0;
    while (t < len) begin
      n++;
      k++;
      t += (k <= 16) ? 250 : 125;
    end
    return n;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_btn(input int which, input int len);
    if (which == 0) up_n = 1'b0; else if (which == 1) dn_n = 1'b0; else mute_n = 1'b0;
    wait_cyc(len);
    up_n = 1'b1; dn_n = 1'b1; mute_n = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    chk("R7 reset position", req_pos_o, 10);
    chk("R7 reset strobe", req_vld_o, 0);
  endtask

  task automatic t_debounce;
    int s0 = strobes;
    hold_btn(0, 10);
    chk("R1 short pulse position", req_pos_o, 10);
    chk("R1 short pulse strobes", strobes - s0, 0);
    hold_btn(0, 25);
    chk("R1 valid press position", req_pos_o, 9);
    chk("R9 one strobe per step", strobes - s0, 1);
  endtask

  task automatic t_lockout;
    int s0 = strobes;
    up_n = 1'b0; wait_cyc(16);
    up_n = 1'b1; wait_cyc(18);
    up_n = 1'b0; wait_cyc(30);
    up_n = 1'b1; wait_cyc(SETTLE);
    chk("R2 second press in lockout ignored", req_pos_o, 8);
    chk("R2 lockout strobes", strobes - s0, 1);
    hold_btn(0, 25);
    chk("R2 press after lockout accepted", req_pos_o, 7);
  endtask

  task automatic t_hold_slow;
    int s0 = strobes;
    int n = steps_for(2100);
    hold_btn(1, 2100);
    chk("R3 slow auto-repeat position", req_pos_o, 7 + n);
    chk("R3 slow auto-repeat strobes", strobes - s0, n);
    model_pos = 7 + n;
  endtask

  task automatic t_up_saturate;
    int s0 = strobes;
    hold_btn(0, 4100);
    chk("R4 up saturates at 0", req_pos_o, 0);
    chk("R4 no strobe past 0", strobes - s0, model_pos);
  endtask

  task automatic t_hold_fast;
    int s0 = strobes;
    int n = steps_for(5700);
    hold_btn(1, 5700);
    chk("R3 fast auto-repeat position", req_pos_o, n);
    chk("R3 fast auto-repeat strobes", strobes - s0, n);
    model_pos = n;
  endtask

  task automatic t_dn_saturate;
    int s0 = strobes;
    hold_btn(1, 3100);
    chk("R4 down saturates at 31", req_pos_o, 31);
    chk("R4 no strobe past 31", strobes - s0, 31 - model_pos);
  endtask

  task automatic t_mute;
    int s0;
    hold_btn(0, 25);
    chk("R4 step up from 31", req_pos_o, 30);
    s0 = strobes;
    hold_btn(2, 25);
    chk("R5 mute enters mute code", req_pos_o, MUTE_CODE);
    chk("R5 mute strobe", strobes - s0, 1);
    s0 = strobes;
    hold_btn(1, 25);
    hold_btn(0, 25);
    chk("R10 up/down while muted", req_pos_o, MUTE_CODE);
    chk("R10 no strobe while muted", strobes - s0, 0);
    hold_btn(2, 25);
    chk("R5 second mute restores", req_pos_o, 30);
    s0 = strobes;
    hold_btn(2, 1500);
    chk("R5 held mute no repeat", req_pos_o, MUTE_CODE);
    chk("R5 held mute single strobe", strobes - s0, 1);
    hold_btn(2, 25);
    chk("R5 restore after held mute", req_pos_o, 30);
  endtask

  task automatic t_chord;
    int s0 = strobes;
    up_n = 1'b0; dn_n = 1'b0; wait_cyc(40);
    up_n = 1'b1; dn_n = 1'b1; wait_cyc(SETTLE);
    chk("R6 chord ignored", req_pos_o, 30);
    chk("R6 chord no strobe", strobes - s0, 0);
    up_n = 1'b0; dn_n = 1'b0; wait_cyc(40);
    up_n = 1'b1; wait_cyc(200);
    dn_n = 1'b1; wait_cyc(SETTLE);
    chk("R6 leftover button after chord ignored", req_pos_o, 30);
    s0 = strobes;
    up_n = 1'b0; wait_cyc(30);
    dn_n = 1'b0; wait_cyc(1500);
    up_n = 1'b1; dn_n = 1'b1; wait_cyc(SETTLE);
    chk("R6 chord stops auto-repeat", req_pos_o, 29);
    chk("R6 chord stops repeat strobes", strobes - s0, 1);
  endtask

  task automatic t_standby;
    int s0 = strobes;
    stby_n = 1'b0; wait_cyc(5);
    chk("R8 standby forces mute code", req_pos_o, MUTE_CODE);
    up_n = 1'b0; wait_cyc(25);
    up_n = 1'b1; wait_cyc(SETTLE);
    chk("R8 buttons ignored in standby", req_pos_o, MUTE_CODE);
    stby_n = 1'b1; wait_cyc(5);
    chk("R8 position restored after standby", req_pos_o, 29);
    chk("R9 standby strobes", strobes - s0, 2);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    t_reset();
    t_debounce();
    t_lockout();
    t_hold_slow();
    t_up_saturate();
    t_hold_fast();
    t_dn_saturate();
    t_mute();
    t_chord();
    t_standby();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule